// File: doc/BRIEF.md
# Flash Programming Command Decoder

This block is the command front end of an on-chip code flash while the device sits in its programming mode. Programming mode is recognised from four pins: the reset pin high, the fetch strobe low, and both the read and write strobe pins high. Leaving that pin state drops any half-finished sequence. In programming mode an external programmer writes a one-byte command on the data port, framed by a low pulse on the command-setup pin. The decoder acts on the byte when that pulse ends.

Some commands only pick a read-back source: normal read, program-margin verify, erase-margin verify or signature bytes. The others arm a two-cycle operation. These are byte program, chip erase and the three lock-bit writes. The armed operation runs during the next low pulse of the program strobe, and that pulse's low time is the operation time. The decoder raises the matching enable towards the flash array and holds the latched address and data steady. On the strobe's rising edge the arming is dropped, so every byte needs a fresh command.

Read data goes out through a separate data-out bus with a drive enable for the pad. Lock-bit status comes back from the array and gates reads and programming. All pins are sampled on the block clock, which runs much faster than the strobes. Each strobe edge is therefore seen one clock after it occurs.

Top module: `flashcmd_dec`

## Requirements
- R1: Commands, program strobes and read drive take effect only while `rst_pin_i`=1, `fetch_n_i`=0, `rd_n_i`=1 and `wr_n_i`=1. Outside that state, command pulses and program strobes are ignored, `rd_oe_o` stays 0, and any armed or running operation is dropped.
- R2: A command byte is taken from `data_i` in the clock cycle that first sees `cmd_n_i` high again after being low. `vmode_o` changes one clock later. The mode codes are 00H normal (`vmode_o`=0), C0H program verify (1), A0H erase verify (2) and 90H signature (3).
- R3: After synchronous reset `vmode_o` is 0 (normal) and no enable is active.
- R4: Command 40H arms a program cycle. The first clock that sees `pgm_n_i` low latches `addr_i` and `data_i` into `pgm_addr_o` and `pgm_data_o` and raises `pgm_en_o`. Both latches hold while the strobe stays low. The first clock that sees `pgm_n_i` high again drops `pgm_en_o` and the arming, so a further strobe without a new 40H does nothing. At most one enable is active at a time.
- R5: Commands 20H (erase), 60H, 70H and 80H (lock bits 1, 2 and 3, on `lock_we_o` bits 0, 1 and 2) raise their enable only if `data_i` is D0H when the program strobe falls. If `data_i` leaves D0H while the strobe is low, the enable drops on the next clock and the operation is abandoned.
- R6: When an erase or lock-bit strobe that reached its enable rises, `vmode_o` returns to 0.
- R7: A program strobe with no armed command raises no enable. This covers a strobe after a mode-only command and a strobe after an unknown command byte. An unknown byte also leaves `vmode_o` unchanged.
- R8: In signature mode the read data is D5H at address 30H and 52H at 31H. At 32H it is AAH when `SIG_HV`=1 and 55H when `SIG_HV`=0. Every other address reads 00H.
- R9: `rd_oe_o` is 1 only while `oe_n_i` is low in programming mode. Outside signature mode and with lock bits 2 and 3 clear, `rd_data_o` equals `arr_rdata_i`.
- R10: With `lock_state_i[1]` or `lock_state_i[2]` set, reads outside signature mode return FFH. Signature reads are unaffected.
- R11: With `lock_state_i[0]` set, a program strobe after 40H raises no `pgm_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| rst_pin_i | input | 1 | Device reset pin level |
| fetch_n_i | input | 1 | Fetch strobe pin level |
| rd_n_i | input | 1 | Read strobe pin level |
| wr_n_i | input | 1 | Write strobe pin level |
| cmd_n_i | input | 1 | Command-setup strobe, active low |
| pgm_n_i | input | 1 | Program strobe, active low |
| oe_n_i | input | 1 | Output-enable strobe, active low |
| data_i | input | 8 | Data port input |
| addr_i | input | 13 | Address in |
| arr_rdata_i | input | 8 | Data read from the flash array |
| lock_state_i | input | 3 | Programmed state of lock bits 1..3 |
| pgm_en_o | output | 1 | Byte program enable |
| erase_en_o | output | 1 | Chip erase enable |
| lock_we_o | output | 3 | Lock bit 1..3 write enables |
| pgm_addr_o | output | 13 | Latched program address |
| pgm_data_o | output | 8 | Latched program data |
| vmode_o | output | 2 | Read mode: 0 normal, 1 program verify, 2 erase verify, 3 signature |
| rd_data_o | output | 8 | Read-back data |
| rd_oe_o | output | 1 | Drive enable for the data port |

## Verification
The program, erase and lock sequences are each run with a correct confirm byte, with a missing confirm byte, and with the confirm byte withdrawn partway through the strobe. These three cases separate a decoder that tests the byte only at the strobe edge from one that watches it for the whole pulse. Repeated strobes without a new command, strobes after unknown bytes, and strobes after the entry pins drop show whether arming is really consumed and cleared. Reads are swept across the signature addresses and across normal addresses under each lock-bit pattern. A cycle-level behavioural model follows every clock, so an enable that arrives or ends one clock off is caught.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        VM_NORMAL = 2'd0,
        VM_PGMV   = 2'd1,
        VM_ERSV   = 2'd2,
        VM_SIG    = 2'd3
    } vmode_e;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_PGM   = 3'd1,
        OP_ERASE = 3'd2,
        OP_LOCK1 = 3'd3,
        OP_LOCK2 = 3'd4,
        OP_LOCK3 = 3'd5
    } op_e;

    typedef struct packed {
        logic   known;
        logic   sets_mode;
        vmode_e mode;
        op_e    op;
    } cmd_t;

    localparam logic [DATA_W-1:0] CONFIRM_BYTE = 8'hD0;

    function automatic cmd_t decode_cmd(input logic [DATA_W-1:0] b);
        cmd_t c;
        c.known     = 1'b1;
        c.sets_mode = 1'b0;
        c.mode      = VM_NORMAL;
        c.op        = OP_NONE;
        case (b)
            8'h00: c.sets_mode = 1'b1;
            8'hC0: begin c.sets_mode = 1'b1; c.mode = VM_PGMV; end
            8'hA0: begin c.sets_mode = 1'b1; c.mode = VM_ERSV; end
            8'h90: begin c.sets_mode = 1'b1; c.mode = VM_SIG;  end
            8'h40: c.op = OP_PGM;
            8'h20: c.op = OP_ERASE;
            8'h60: c.op = OP_LOCK1;
            8'h70: c.op = OP_LOCK2;
            8'h80: c.op = OP_LOCK3;
            default: c.known = 1'b0;
        endcase
        return c;
    endfunction

    // operations that need the confirm byte through the strobe
    function automatic logic is_long_op(input op_e o);
        return (o == OP_ERASE) || (o == OP_LOCK1) || (o == OP_LOCK2) || (o == OP_LOCK3);
    endfunction

    function automatic logic [DATA_W-1:0] sig_byte(input logic [7:0] a, input logic hv);
        case (a)
            8'h30:   return 8'hD5;
            8'h31:   return 8'h52;
            8'h32:   return hv ? 8'hAA : 8'h55;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/flashcmd_entry.sv
module flashcmd_entry (
    input  logic clk,
    input  logic rst,
    input  logic rst_pin_i,
    input  logic fetch_n_i,
    input  logic rd_n_i,
    input  logic wr_n_i,
    input  logic cmd_n_i,
    input  logic pgm_n_i,
    output logic in_mode_o,
    output logic cmd_rise_o,
    output logic pgm_fall_o,
    output logic pgm_rise_o
);
    localparam int NSTRB = 2;

    logic [NSTRB-1:0] strb_now;
    logic [NSTRB-1:0] strb_q;
    logic [NSTRB-1:0] rise;
    logic [NSTRB-1:0] fall;

    assign strb_now  = {pgm_n_i, cmd_n_i};
    assign in_mode_o = rst_pin_i & ~fetch_n_i & rd_n_i & wr_n_i;

    always_ff @(posedge clk) begin
        if (rst) strb_q <= '1;
        else     strb_q <= strb_now;
    end

    for (genvar gi = 0; gi < NSTRB; gi++) begin : g_edge
        assign rise[gi] = in_mode_o &  strb_now[gi] & ~strb_q[gi];
        assign fall[gi] = in_mode_o & ~strb_now[gi] &  strb_q[gi];
    end

    assign cmd_rise_o = rise[0];
    assign pgm_rise_o = rise[1];
    assign pgm_fall_o = fall[1];
endmodule

// File: rtl/flashcmd_seq.sv
module flashcmd_seq
    import flashcmd_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_mode_i,
    input  logic              cmd_rise_i,
    input  logic              pgm_fall_i,
    input  logic              pgm_rise_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              lock1_i,
    output vmode_e            vmode_o,
    output op_e               act_o,
    output logic [ADDR_W-1:0] pgm_addr_o,
    output logic [DATA_W-1:0] pgm_data_o
);
    cmd_t dec;
    op_e  arm_q;

    always_comb dec = decode_cmd(data_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            vmode_o    <= VM_NORMAL;
            arm_q      <= OP_NONE;
            act_o      <= OP_NONE;
            pgm_addr_o <= '0;
            pgm_data_o <= '0;
        end else if (!in_mode_i) begin
            arm_q <= OP_NONE;
            act_o <= OP_NONE;
        end else begin
            if (cmd_rise_i) begin
                if (dec.known) begin
                    if (dec.sets_mode) vmode_o <= dec.mode;
                    arm_q <= dec.op;
                end else begin
                    arm_q <= OP_NONE;
                end
            end
            if (pgm_fall_i) begin
                if (arm_q == OP_PGM && !lock1_i) begin
                    act_o      <= OP_PGM;
                    pgm_addr_o <= addr_i;
                    pgm_data_o <= data_i;
                end else if (is_long_op(arm_q) && data_i == CONFIRM_BYTE) begin
                    act_o <= arm_q;
                end
            end else if (pgm_rise_i) begin
                if (is_long_op(act_o)) vmode_o <= VM_NORMAL;
                arm_q <= OP_NONE;
                act_o <= OP_NONE;
            end else if (is_long_op(act_o) && data_i != CONFIRM_BYTE) begin
                arm_q <= OP_NONE;
                act_o <= OP_NONE;
            end
        end
    end
endmodule

// File: rtl/flashcmd_rdmux.sv
module flashcmd_rdmux
    import flashcmd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter bit SIG_HV = 1'b1
) (
    input  vmode_e            vmode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] arr_rdata_i,
    input  logic [1:0]        read_lock_i,
    input  logic              in_mode_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_oe_o
);
    localparam int LOW_W = 8;

    logic hi_zero;
    logic [DATA_W-1:0] sig_val;

    assign hi_zero = (addr_i[ADDR_W-1:LOW_W] == '0);
    assign sig_val = hi_zero ? sig_byte(addr_i[LOW_W-1:0], SIG_HV) : '0;

    always_comb begin
        if (vmode_i == VM_SIG)   rd_data_o = sig_val;
        else if (|read_lock_i)   rd_data_o = '1;
        else                     rd_data_o = arr_rdata_i;
    end

    assign rd_oe_o = in_mode_i & ~oe_n_i;
endmodule

// File: rtl/flashcmd_dec.sv
module flashcmd_dec
    import flashcmd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter bit SIG_HV = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_pin_i,
    input  logic              fetch_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic              cmd_n_i,
    input  logic              pgm_n_i,
    input  logic              oe_n_i,
    input  logic [7:0]        data_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        arr_rdata_i,
    input  logic [2:0]        lock_state_i,
    output logic              pgm_en_o,
    output logic              erase_en_o,
    output logic [2:0]        lock_we_o,
    output logic [ADDR_W-1:0] pgm_addr_o,
    output logic [7:0]        pgm_data_o,
    output logic [1:0]        vmode_o,
    output logic [7:0]        rd_data_o,
    output logic              rd_oe_o
);
    localparam int NLOCK = 3;

    logic   in_mode, cmd_rise, pgm_fall, pgm_rise;
    vmode_e vmode;
    op_e    act;

    flashcmd_entry u_entry (
        .clk        (clk),
        .rst        (rst),
        .rst_pin_i  (rst_pin_i),
        .fetch_n_i  (fetch_n_i),
        .rd_n_i     (rd_n_i),
        .wr_n_i     (wr_n_i),
        .cmd_n_i    (cmd_n_i),
        .pgm_n_i    (pgm_n_i),
        .in_mode_o  (in_mode),
        .cmd_rise_o (cmd_rise),
        .pgm_fall_o (pgm_fall),
        .pgm_rise_o (pgm_rise)
    );

    flashcmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .in_mode_i  (in_mode),
        .cmd_rise_i (cmd_rise),
        .pgm_fall_i (pgm_fall),
        .pgm_rise_i (pgm_rise),
        .data_i     (data_i),
        .addr_i     (addr_i),
        .lock1_i    (lock_state_i[0]),
        .vmode_o    (vmode),
        .act_o      (act),
        .pgm_addr_o (pgm_addr_o),
        .pgm_data_o (pgm_data_o)
    );

    flashcmd_rdmux #(.ADDR_W(ADDR_W), .SIG_HV(SIG_HV)) u_rdmux (
        .vmode_i     (vmode),
        .addr_i      (addr_i),
        .arr_rdata_i (arr_rdata_i),
        .read_lock_i (lock_state_i[2:1]),
        .in_mode_i   (in_mode),
        .oe_n_i      (oe_n_i),
        .rd_data_o   (rd_data_o),
        .rd_oe_o     (rd_oe_o)
    );

    assign pgm_en_o   = (act == OP_PGM);
    assign erase_en_o = (act == OP_ERASE);
    assign vmode_o    = vmode;

    for (genvar gi = 0; gi < NLOCK; gi++) begin : g_lock
        localparam op_e LK_OP = op_e'(3'(int'(OP_LOCK1) + gi));
        assign lock_we_o[gi] = (act == LK_OP);
    end
endmodule

// File: rtl/flashcmd_dec_chk.sv
module flashcmd_dec_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              rst_pin_i,
    input logic              fetch_n_i,
    input logic              rd_n_i,
    input logic              wr_n_i,
    input logic              pgm_n_i,
    input logic              oe_n_i,
    input logic [7:0]        data_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [2:0]        lock_state_i,
    input logic              pgm_en_o,
    input logic              erase_en_o,
    input logic [2:0]        lock_we_o,
    input logic [ADDR_W-1:0] pgm_addr_o,
    input logic [7:0]        pgm_data_o,
    input logic [1:0]        vmode_o,
    input logic [7:0]        rd_data_o,
    input logic              rd_oe_o
);
    logic pins_ok;
    assign pins_ok = rst_pin_i & ~fetch_n_i & rd_n_i & wr_n_i;

    // R3
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (vmode_o == 2'd0 && !pgm_en_o && !erase_en_o && lock_we_o == 3'b000));

    // R4
    one_op_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pgm_en_o, erase_en_o, lock_we_o}));

    // R1
    entry_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !pins_ok |=> (!pgm_en_o && !erase_en_o && lock_we_o == 3'b000));

    // R9
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        rd_oe_o |-> (!oe_n_i && pins_ok));

    // R4
    pgm_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pgm_en_o) |-> !$past(pgm_n_i));

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pgm_en_o && $past(pgm_en_o)) |-> ($stable(pgm_addr_o) && $stable(pgm_data_o)));

    // R5
    confirm_chk: assert property (@(posedge clk) disable iff (rst)
        (erase_en_o || lock_we_o != 3'b000) |-> ($past(data_i) == 8'hD0));

    // R11
    lock1_block_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pgm_en_o) |-> !$past(lock_state_i[0]));

    // R8
    sig_chk: assert property (@(posedge clk) disable iff (rst)
        (vmode_o == 2'd3 && addr_i == ADDR_W'(8'h30)) |-> rd_data_o == 8'hD5);

    // R10
    lock_read_chk: assert property (@(posedge clk) disable iff (rst)
        (vmode_o != 2'd3 && (lock_state_i[1] || lock_state_i[2])) |-> rd_data_o == 8'hFF);
endmodule

bind flashcmd_dec flashcmd_dec_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rst_pin_i    (rst_pin_i),
    .fetch_n_i    (fetch_n_i),
    .rd_n_i       (rd_n_i),
    .wr_n_i       (wr_n_i),
    .pgm_n_i      (pgm_n_i),
    .oe_n_i       (oe_n_i),
    .data_i       (data_i),
    .addr_i       (addr_i),
    .lock_state_i (lock_state_i),
    .pgm_en_o     (pgm_en_o),
    .erase_en_o   (erase_en_o),
    .lock_we_o    (lock_we_o),
    .pgm_addr_o   (pgm_addr_o),
    .pgm_data_o   (pgm_data_o),
    .vmode_o      (vmode_o),
    .rd_data_o    (rd_data_o),
    .rd_oe_o      (rd_oe_o)
);

// File: tb/flashcmd_dec_tb_top.sv
module flashcmd_dec_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_pin = 1'b1, fetch_n = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic        cmd_n = 1'b1, pgm_n = 1'b1, oe_n = 1'b1;
    logic [7:0]  data = 8'h00;
    logic [12:0] addr = 13'h0;
    logic [7:0]  arr;
    logic [2:0]  lock = 3'b000;
    logic        pgm_en, erase_en, rd_oe;
    logic [2:0]  lock_we;
    logic [12:0] pgm_addr;
    logic [7:0]  pgm_data, rd_data;
    logic [1:0]  vmode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    assign arr = addr[7:0] ^ 8'h3C;

    flashcmd_dec dut_i (
        .clk(clk), .rst(rst), .rst_pin_i(rst_pin), .fetch_n_i(fetch_n),
        .rd_n_i(rd_n), .wr_n_i(wr_n), .cmd_n_i(cmd_n), .pgm_n_i(pgm_n),
        .oe_n_i(oe_n), .data_i(data), .addr_i(addr), .arr_rdata_i(arr),
        .lock_state_i(lock), .pgm_en_o(pgm_en), .erase_en_o(erase_en),
        .lock_we_o(lock_we), .pgm_addr_o(pgm_addr), .pgm_data_o(pgm_data),
        .vmode_o(vmode), .rd_data_o(rd_data), .rd_oe_o(rd_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // op coding: 0 none, 1 program, 2 erase, 3..5 lock bit 1..3
    int m_mode = 0, m_arm = 0, m_act = 0;
    int m_paddr = 0, m_pdata = 0;
    bit m_cmd_prev = 1, m_pgm_prev = 1;

    always @(posedge clk) begin
        bit pins;
        int na, nact, nmode;
        if (rst) begin
            m_mode <= 0; m_arm <= 0; m_act <= 0; m_paddr <= 0; m_pdata <= 0;
            m_cmd_prev <= 1; m_pgm_prev <= 1;
        end else begin
            pins  = rst_pin && !fetch_n && rd_n && wr_n;
            na    = m_arm; nact = m_act; nmode = m_mode;
            if (!pins) begin
                na = 0; nact = 0;
            end else begin
                if (cmd_n && !m_cmd_prev) begin
                    na = 0;
                    case (data)
                        8'h00: nmode = 0;
                        8'hC0: nmode = 1;
                        8'hA0: nmode = 2;
                        8'h90: nmode = 3;
                        8'h40: na = 1;
                        8'h20: na = 2;
                        8'h60: na = 3;
                        8'h70: na = 4;
                        8'h80: na = 5;
                        default: ;
                    endcase
                end
                if (!pgm_n && m_pgm_prev) begin
                    if (m_arm == 1 && !lock[0]) begin
                        nact = 1; m_paddr <= int'(addr); m_pdata <= int'(data);
                    end else if (m_arm >= 2 && data == 8'hD0) nact = m_arm;
                end else if (pgm_n && !m_pgm_prev) begin
                    if (m_act >= 2) nmode = 0;
                    na = 0; nact = 0;
                end else if (m_act >= 2 && data != 8'hD0) begin
                    na = 0; nact = 0;
                end
            end
            m_arm <= na; m_act <= nact; m_mode <= nmode;
            m_cmd_prev <= cmd_n; m_pgm_prev <= pgm_n;
        end
    end

    function automatic logic [7:0] m_read();
        if (m_mode == 3) begin
            if (addr == 13'h30) return 8'hD5;
            if (addr == 13'h31) return 8'h52;
            if (addr == 13'h32) return 8'hAA;
            return 8'h00;
        end
        if (lock[1] || lock[2]) return 8'hFF;
        return arr;
    endfunction

    // per-clock comparison, sampled away from the edge
    always begin
        @(posedge clk);
        #2;
        if (!rst && !done) begin
            chk("R2 vmode", 32'(vmode), 32'(m_mode));
            chk("R4 pgm_en", 32'(pgm_en), 32'(m_act == 1));
            chk("R5 erase_en", 32'(erase_en), 32'(m_act == 2));
            chk("R5 lock_we", 32'(lock_we), {29'd0, m_act == 5, m_act == 4, m_act == 3});
            chk("R9 rd_oe", 32'(rd_oe),
                32'(rst_pin && !fetch_n && rd_n && wr_n && !oe_n));
            if (rd_oe) chk("R8 rd_data", 32'(rd_data), 32'(m_read()));
            if (pgm_en) begin
                chk("R4 pgm_addr", 32'(pgm_addr), 32'(m_paddr));
                chk("R4 pgm_data", 32'(pgm_data), 32'(m_pdata));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] b);
        @(negedge clk); data = b; cmd_n = 1'b0;
        tick(2); cmd_n = 1'b1;
        tick(2);
    endtask

    task automatic sample();
        @(posedge clk); #2;
    endtask

    // strobe with fixed data, checks the chosen enable vector mid-pulse and after
    task automatic strobe(input logic [12:0] a, input logic [7:0] d,
                          input string tag, input logic [4:0] exp_mid);
        @(negedge clk); addr = a; data = d; pgm_n = 1'b0;
        sample();
        chk(tag, {27'd0, pgm_en, erase_en, lock_we}, {27'd0, exp_mid});
        tick(3); pgm_n = 1'b1;
        sample();
        chk(tag, {27'd0, pgm_en, erase_en, lock_we}, 32'd0);
        tick(2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        tick(4);
        rst = 1'b0;
        sample();
        // R3
        chk("R3 vmode", 32'(vmode), 0);
        chk("R3 enables", {27'd0, pgm_en, erase_en, lock_we}, 0);
        chk("R3 rd_oe", 32'(rd_oe), 0);

        // R2 mode commands
        send_cmd(8'hC0); chk("R2 C0", 32'(vmode), 1);
        send_cmd(8'hA0); chk("R2 A0", 32'(vmode), 2);
        send_cmd(8'h90); chk("R2 90", 32'(vmode), 3);

        // R8 signature reads, R9 oe gating
        @(negedge clk); oe_n = 1'b0; addr = 13'h30; sample(); chk("R8 sig30", 32'(rd_data), 32'hD5);
        @(negedge clk); addr = 13'h31; sample(); chk("R8 sig31", 32'(rd_data), 32'h52);
        @(negedge clk); addr = 13'h32; sample(); chk("R8 sig32", 32'(rd_data), 32'hAA);
        @(negedge clk); addr = 13'h130; sample(); chk("R8 sig other", 32'(rd_data), 32'h00);
        chk("R9 oe on", 32'(rd_oe), 1);
        @(negedge clk); oe_n = 1'b1; sample(); chk("R9 oe off", 32'(rd_oe), 0);

        // R7 unknown byte keeps mode
        send_cmd(8'h55); chk("R7 unknown keeps mode", 32'(vmode), 3);
        strobe(13'h10, 8'hD0, "R7 strobe after unknown", 5'b0);
        send_cmd(8'h00); chk("R2 00", 32'(vmode), 0);
        strobe(13'h11, 8'hD0, "R7 strobe after mode cmd", 5'b0);

        // R9 normal read
        @(negedge clk); oe_n = 1'b0; addr = 13'h005; sample();
        chk("R9 normal read", 32'(rd_data), 32'(8'h05 ^ 8'h3C));
        @(negedge clk); oe_n = 1'b1;

        // R4 program cycle with latch hold
        send_cmd(8'h40);
        @(negedge clk); addr = 13'h123; data = 8'h5A; pgm_n = 1'b0;
        sample(); chk("R4 pgm_en on", 32'(pgm_en), 1);
        chk("R4 addr", 32'(pgm_addr), 32'h123); chk("R4 data", 32'(pgm_data), 32'h5A);
        @(negedge clk); addr = 13'h1FFF; data = 8'h00;
        sample(); chk("R4 latch holds", 32'(pgm_addr), 32'h123);
        tick(1); pgm_n = 1'b1;
        sample(); chk("R4 pgm_en off", 32'(pgm_en), 0);
        tick(2);
        strobe(13'h124, 8'hA5, "R4 rearm needed", 5'b0);
        send_cmd(8'h40);
        strobe(13'h1FFF, 8'h77, "R4 top address", 5'b10000);

        // R5 + R6 erase from program-verify mode
        send_cmd(8'hC0); send_cmd(8'h20);
        chk("R6 mode before erase", 32'(vmode), 1);
        strobe(13'h0, 8'hD0, "R5 erase", 5'b01000);
        chk("R6 back to normal", 32'(vmode), 0);

        // R5 abort when confirm withdrawn, mode kept
        send_cmd(8'hA0); send_cmd(8'h20);
        @(negedge clk); data = 8'hD0; pgm_n = 1'b0;
        sample(); chk("R5 erase start", 32'(erase_en), 1);
        @(negedge clk); data = 8'h00;
        sample(); chk("R5 abort", 32'(erase_en), 0);
        tick(1); pgm_n = 1'b1; tick(2);
        chk("R6 abort keeps mode", 32'(vmode), 2);

        // R5 missing confirm
        send_cmd(8'h60);
        strobe(13'h0, 8'h00, "R5 no confirm", 5'b0);

        // R5 lock writes, R6
        send_cmd(8'h60); strobe(13'h0, 8'hD0, "R5 lock1", 5'b00001);
        send_cmd(8'h70); strobe(13'h0, 8'hD0, "R5 lock2", 5'b00010);
        send_cmd(8'h90); send_cmd(8'h80);
        strobe(13'h0, 8'hD0, "R5 lock3", 5'b00100);
        chk("R6 lock returns normal", 32'(vmode), 0);

        // R1 outside programming mode
        @(negedge clk); rd_n = 1'b0;
        send_cmd(8'h90); chk("R1 cmd ignored", 32'(vmode), 0);
        @(negedge clk); oe_n = 1'b0; sample(); chk("R1 no drive", 32'(rd_oe), 0);
        @(negedge clk); oe_n = 1'b1; rd_n = 1'b1;
        send_cmd(8'h40);
        @(negedge clk); fetch_n = 1'b1; tick(1); fetch_n = 1'b0;
        strobe(13'h2, 8'h12, "R1 arming dropped", 5'b0);

        // R11 lock bit 1 blocks programming
        @(negedge clk); lock = 3'b001;
        send_cmd(8'h40);
        strobe(13'h3, 8'h34, "R11 program blocked", 5'b0);

        // R10 read lock
        @(negedge clk); lock = 3'b010; oe_n = 1'b0; addr = 13'h44;
        sample(); chk("R10 lock2 read", 32'(rd_data), 32'hFF);
        @(negedge clk); lock = 3'b100;
        sample(); chk("R10 lock3 read", 32'(rd_data), 32'hFF);
        send_cmd(8'h90);
        @(negedge clk); addr = 13'h31;
        sample(); chk("R10 sig unaffected", 32'(rd_data), 32'h52);
        @(negedge clk); oe_n = 1'b1; lock = 3'b000;
        tick(3);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule